// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Logic

This block keeps the receive and transmit interrupt state of a two-channel serial controller and turns it into the values software sees. It produces three results. The first is one interrupt request line. The second is a vector register that names the source that most recently took service. The third is a pending register with one bit for each source. Receive and transmit events set interrupts. The channel's data-register read, a "clear transmit" command and a "reset highest under-service" command clear them. Channel A is index 0 and channel B is index 1 on every two-bit port.

Each channel runs a small service state machine with three states:

- `SVC_IDLE`: nothing is under service.
- `SVC_RX`: the receive interrupt is under service.
- `SVC_TX`: the transmit interrupt is under service.

The state machine moves between these states as follows:

- A receive event moves `SVC_IDLE` or `SVC_RX` to `SVC_RX`.
- A transmit event moves `SVC_IDLE` or `SVC_TX` to `SVC_TX`.
- A receive clear takes `SVC_RX` to `SVC_IDLE`. If transmit is still pending, the channel goes to `SVC_TX` instead (re-raise).
- A transmit clear takes `SVC_TX` to `SVC_IDLE`. If receive is still pending, the channel goes to `SVC_RX` instead (re-raise).
- Any other combination of state and strobes holds the state.

In one cycle the steps apply in this order: receive clear, transmit clear, receive set, transmit set. Because the sets come last, a set wins over a clear that arrives in the same cycle.

The vector register is shared between the channels. A channel writes it each time a source enters or refreshes service, and each time a clear runs. If both channels write in the same cycle, channel A's value is loaded.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, `rr2_vec` is 0x00, `rr3_pend` is 0x00, `rx_avail` is 00 and `irq` is low.
- R2: A pulse on `rx_evt[i]` sets the receive pending bit and `rx_avail[i]` one cycle later. The receive pending bit is `rr3_pend` bit 5 for A and bit 2 for B.
- R3: A pulse on `tx_evt[i]` sets the transmit pending bit one cycle later. The transmit pending bit is `rr3_pend` bit 4 for A and bit 1 for B.
- R4: The vector values depend on `status_hi`.
  - With `status_hi` high: receive A 0x30, receive B 0x20, transmit A 0x10, no interrupt 0x60.
  - With `status_hi` low: receive A 0x0C, receive B 0x04, transmit A 0x08, no interrupt 0x06.
  - Transmit B is always 0x00.
- R5: A receive event updates the vector only when transmit is not under service on that channel. A transmit event updates the vector only when receive is not under service on that channel. In both cases the pending bit is still set.
- R6: `cmd_code` 7 is "reset highest under-service". It clears the receive interrupt when receive is under service on channel `cmd_chan`, and otherwise clears the transmit interrupt when transmit is under service. With nothing under service it has no effect.
- R7: `cmd_code` 5 clears the transmit interrupt of channel `cmd_chan` and writes the no-interrupt vector.
- R8: Clearing a receive interrupt while transmit is still pending puts transmit under service and writes its vector. Clearing a transmit interrupt while receive is still pending does the same for receive.
- R9: A pulse on `data_rd[i]` clears `rx_avail[i]` and the receive interrupt of that channel. It does not clear the transmit interrupt.
- R10: `irq` is high when any channel meets one of these conditions:
  - `tx_ie` is set and transmit is pending;
  - its `rx_mode` field is 01 or 10 and receive is pending;
  - `brk_ie` and `brk_stat` are both set.
  Otherwise `irq` is low.
- R11: A set and a clear for the same source in the same cycle leave that source pending and under service.
- R12: When both channels write the vector in the same cycle, channel A's value is loaded.
- R13: In a cycle with no event, no read and no command, `rr2_vec` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_hi | input | 1 | Selects the high vector encoding |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_mode | input | 4 | Receive interrupt mode, 2 bits per channel (A in bits 1:0) |
| brk_ie | input | 2 | Break interrupt enable per channel |
| brk_stat | input | 2 | Break condition status per channel |
| rx_evt | input | 2 | Receive character arrived, one-cycle pulse |
| tx_evt | input | 2 | Transmit buffer emptied, one-cycle pulse |
| data_rd | input | 2 | Data register read, one-cycle pulse |
| cmd_we | input | 1 | Command strobe |
| cmd_chan | input | 1 | Target channel of the command (0 = A) |
| cmd_code | input | 3 | Command code (5 clear transmit, 7 reset highest under-service) |
| irq | output | 1 | Combined interrupt request |
| rr2_vec | output | 8 | Interrupt vector register |
| rr3_pend | output | 8 | Pending register |
| rx_avail | output | 2 | Receive character available per channel |

## Verification
The bench targets the service lockout.
- A transmit event that arrives while receive is under service must leave the vector alone. A design that dropped the lockout would report the transmit code too early.
- After each clear, the other source must be re-raised. A design that forgot the re-raise would show the no-interrupt code while transmit is still pending.

The bench puts set and clear on the same source in one cycle. A design that let the clear win would lose the pending bit.

It covers the remaining corners:
- both channels writing the vector in the same cycle, where a reversed priority shows channel B's code;
- a reset-under-service command with nothing under service, which must change nothing;
- each enable gate on `irq`, including receive modes 00 and 11 and break alone.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int NCH   = 2;
    localparam int VEC_W = 8;
    localparam int PND_W = 8;
    localparam int CMD_W = 3;
    localparam int MODE_W = 2;

    localparam int CH_A = 0;
    localparam int CH_B = 1;

    localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'd5;
    localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'd7;

    localparam int PB_RX_A = 5;
    localparam int PB_TX_A = 4;
    localparam int PB_RX_B = 2;
    localparam int PB_TX_B = 1;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_RX   = 2'd1,
        SVC_TX   = 2'd2
    } svc_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RX   = 2'd1,
        SRC_TX   = 2'd2
    } src_e;

    function automatic logic [VEC_W-1:0] vec_code(input logic is_b,
                                                  input src_e src,
                                                  input logic hi);
        logic [VEC_W-1:0] v;
        case (src)
            SRC_RX:  v = is_b ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
            SRC_TX:  v = is_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
    import sio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt,
    input  logic tx_evt,
    input  logic rd_evt,
    input  logic clr_tx_cmd,
    input  logic rst_ius_cmd,
    output logic rx_pend,
    output logic tx_pend,
    output logic rx_avail,
    output logic vec_we,
    output src_e vec_src
);

    svc_e st_q, st_d;
    logic rp_q, rp_d;
    logic tp_q, tp_d;
    logic av_q, av_d;
    logic clr_rx, clr_tx;
    logic we_d;
    src_e src_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SVC_IDLE;
            rp_q <= 1'b0;
            tp_q <= 1'b0;
            av_q <= 1'b0;
        end else begin
            st_q <= st_d;
            rp_q <= rp_d;
            tp_q <= tp_d;
            av_q <= av_d;
        end
    end

    // next state: clears first, then sets, so sets win
    always_comb begin
        st_d   = st_q;
        rp_d   = rp_q;
        tp_d   = tp_q;
        we_d   = 1'b0;
        src_d  = SRC_NONE;
        clr_rx = rd_evt;
        clr_tx = clr_tx_cmd;

        unique case (st_q)
            SVC_RX:   if (rst_ius_cmd) clr_rx = 1'b1;
            SVC_TX:   if (rst_ius_cmd) clr_tx = 1'b1;
            default:  ;
        endcase

        if (clr_rx) begin
            rp_d  = 1'b0;
            if (st_d == SVC_RX) st_d = SVC_IDLE;
            we_d  = 1'b1;
            src_d = SRC_NONE;
            if (tp_d) begin
                st_d  = SVC_TX;
                src_d = SRC_TX;
            end
        end

        if (clr_tx) begin
            tp_d  = 1'b0;
            if (st_d == SVC_TX) st_d = SVC_IDLE;
            we_d  = 1'b1;
            src_d = SRC_NONE;
            if (rp_d) begin
                st_d  = SVC_RX;
                src_d = SRC_RX;
            end
        end

        if (rx_evt) begin
            rp_d = 1'b1;
            if (st_d != SVC_TX) begin
                st_d  = SVC_RX;
                we_d  = 1'b1;
                src_d = SRC_RX;
            end
        end

        if (tx_evt) begin
            tp_d = 1'b1;
            if (st_d != SVC_RX) begin
                st_d  = SVC_TX;
                we_d  = 1'b1;
                src_d = SRC_TX;
            end
        end

        if (rx_evt)      av_d = 1'b1;
        else if (rd_evt) av_d = 1'b0;
        else             av_d = av_q;
    end

    // outputs
    always_comb begin
        rx_pend  = rp_q;
        tx_pend  = tp_q;
        rx_avail = av_q;
        vec_we   = we_d;
        vec_src  = src_d;
    end

endmodule

// File: rtl/sio_irq_vecsel.sv
module sio_irq_vecsel
    import sio_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                status_hi,
    input  logic [NCH-1:0]      we,
    input  src_e [NCH-1:0]      src,
    output logic [VEC_W-1:0]    vec
);

    logic [VEC_W-1:0] code [NCH];
    logic [VEC_W-1:0] pick;
    logic             any_we;

    for (genvar i = 0; i < NCH; i++) begin : g_code
        assign code[i] = vec_code(i == CH_B, src[i], status_hi);
    end

    // lowest index (channel A) has priority
    always_comb begin
        pick   = vec;
        any_we = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (we[i]) begin
                pick   = code[i];
                any_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      vec <= '0;
        else if (any_we) vec <= pick;
    end

endmodule

// File: rtl/sio_irq_req.sv
module sio_irq_req
    import sio_irq_pkg::*;
(
    input  logic [NCH-1:0]        tx_ie,
    input  logic [MODE_W*NCH-1:0] rx_mode,
    input  logic [NCH-1:0]        brk_ie,
    input  logic [NCH-1:0]        brk_stat,
    input  logic [NCH-1:0]        rx_pend,
    input  logic [NCH-1:0]        tx_pend,
    output logic                  irq
);

    logic [NCH-1:0] chan_req;

    for (genvar i = 0; i < NCH; i++) begin : g_req
        logic rx_on;
        assign rx_on = (rx_mode[MODE_W*i +: MODE_W] == 2'b01) ||
                       (rx_mode[MODE_W*i +: MODE_W] == 2'b10);
        assign chan_req[i] = (tx_ie[i] & tx_pend[i]) |
                             (rx_on & rx_pend[i]) |
                             (brk_ie[i] & brk_stat[i]);
    end

    assign irq = |chan_req;

endmodule

// File: rtl/sio_irq_vector.sv
module sio_irq_vector
    import sio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  status_hi,
    input  logic [NCH-1:0]        tx_ie,
    input  logic [MODE_W*NCH-1:0] rx_mode,
    input  logic [NCH-1:0]        brk_ie,
    input  logic [NCH-1:0]        brk_stat,
    input  logic [NCH-1:0]        rx_evt,
    input  logic [NCH-1:0]        tx_evt,
    input  logic [NCH-1:0]        data_rd,
    input  logic                  cmd_we,
    input  logic                  cmd_chan,
    input  logic [CMD_W-1:0]      cmd_code,
    output logic                  irq,
    output logic [VEC_W-1:0]      rr2_vec,
    output logic [PND_W-1:0]      rr3_pend,
    output logic [NCH-1:0]        rx_avail
);

    logic [NCH-1:0] rx_pend;
    logic [NCH-1:0] tx_pend;
    logic [NCH-1:0] vec_we;
    src_e [NCH-1:0] vec_src;
    logic [NCH-1:0] clr_tx_cmd;
    logic [NCH-1:0] rst_ius_cmd;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign clr_tx_cmd[i]  = cmd_we && (cmd_chan == i[0]) && (cmd_code == CMD_CLR_TX);
        assign rst_ius_cmd[i] = cmd_we && (cmd_chan == i[0]) && (cmd_code == CMD_RST_IUS);

        sio_irq_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .rx_evt      (rx_evt[i]),
            .tx_evt      (tx_evt[i]),
            .rd_evt      (data_rd[i]),
            .clr_tx_cmd  (clr_tx_cmd[i]),
            .rst_ius_cmd (rst_ius_cmd[i]),
            .rx_pend     (rx_pend[i]),
            .tx_pend     (tx_pend[i]),
            .rx_avail    (rx_avail[i]),
            .vec_we      (vec_we[i]),
            .vec_src     (vec_src[i])
        );
    end

    sio_irq_vecsel u_vecsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_hi (status_hi),
        .we        (vec_we),
        .src       (vec_src),
        .vec       (rr2_vec)
    );

    sio_irq_req u_req (
        .tx_ie    (tx_ie),
        .rx_mode  (rx_mode),
        .brk_ie   (brk_ie),
        .brk_stat (brk_stat),
        .rx_pend  (rx_pend),
        .tx_pend  (tx_pend),
        .irq      (irq)
    );

    always_comb begin
        rr3_pend          = '0;
        rr3_pend[PB_RX_A] = rx_pend[CH_A];
        rr3_pend[PB_TX_A] = tx_pend[CH_A];
        rr3_pend[PB_RX_B] = rx_pend[CH_B];
        rr3_pend[PB_TX_B] = tx_pend[CH_B];
    end

endmodule

// File: rtl/sio_irq_vector_chk.sv
module sio_irq_vector_chk
    import sio_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NCH-1:0]     rx_evt,
    input logic [NCH-1:0]     tx_evt,
    input logic [NCH-1:0]     data_rd,
    input logic               cmd_we,
    input logic               cmd_chan,
    input logic [CMD_W-1:0]   cmd_code,
    input logic [NCH-1:0]     brk_ie,
    input logic [NCH-1:0]     brk_stat,
    input logic               irq,
    input logic [VEC_W-1:0]   rr2_vec,
    input logic [PND_W-1:0]   rr3_pend,
    input logic [NCH-1:0]     rx_avail,
    input logic [NCH-1:0]     rx_pend,
    input logic [NCH-1:0]     tx_pend
);

    // R2
    rx_set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt[CH_A] |=> (rr3_pend[PB_RX_A] && rx_avail[CH_A]));

    // R7
    clr_tx_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (cmd_chan == 1'b0) && (cmd_code == CMD_CLR_TX) && !tx_evt[CH_A])
        |=> !rr3_pend[PB_TX_A]);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd[CH_B] && !rx_evt[CH_B]) |=> (!rx_avail[CH_B] && !rr3_pend[PB_RX_B]));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rx_pend) && !(|tx_pend) && !(|(brk_ie & brk_stat))) |-> !irq);

    // R11
    tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt[CH_B] |=> rr3_pend[PB_TX_B]);

    // R13
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rx_evt) && !(|tx_evt) && !(|data_rd) && !cmd_we) |=> $stable(rr2_vec));

endmodule

bind sio_irq_vector sio_irq_vector_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_evt   (rx_evt),
    .tx_evt   (tx_evt),
    .data_rd  (data_rd),
    .cmd_we   (cmd_we),
    .cmd_chan (cmd_chan),
    .cmd_code (cmd_code),
    .brk_ie   (brk_ie),
    .brk_stat (brk_stat),
    .irq      (irq),
    .rr2_vec  (rr2_vec),
    .rr3_pend (rr3_pend),
    .rx_avail (rx_avail),
    .rx_pend  (rx_pend),
    .tx_pend  (tx_pend)
);

// File: tb/sio_irq_vector_tb.sv
module sio_irq_vector_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_hi = 1'b0;
    logic [1:0] tx_ie = 2'b11;
    logic [3:0] rx_mode = 4'b0101;
    logic [1:0] brk_ie = 2'b00;
    logic [1:0] brk_stat = 2'b00;
    logic [1:0] rx_evt = 2'b00;
    logic [1:0] tx_evt = 2'b00;
    logic [1:0] data_rd = 2'b00;
    logic       cmd_we = 1'b0;
    logic       cmd_chan = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       irq;
    logic [7:0] rr2_vec;
    logic [7:0] rr3_pend;
    logic [1:0] rx_avail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] vec;
        logic [7:0] pend;
        logic       irq;
        logic [1:0] av;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    sio_irq_vector u_dut (
        .clk (clk), .rst_n (rst_n), .status_hi (status_hi),
        .tx_ie (tx_ie), .rx_mode (rx_mode), .brk_ie (brk_ie),
        .brk_stat (brk_stat), .rx_evt (rx_evt), .tx_evt (tx_evt),
        .data_rd (data_rd), .cmd_we (cmd_we), .cmd_chan (cmd_chan),
        .cmd_code (cmd_code), .irq (irq), .rr2_vec (rr2_vec),
        .rr3_pend (rr3_pend), .rx_avail (rx_avail)
    );

    // monitor: compares one expected item after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rr2_vec !== e.vec || rr3_pend !== e.pend ||
                    irq !== e.irq || rx_avail !== e.av) begin
                    errors++;
                    $display("FAIL %s: vec %h/%h pend %h/%h irq %b/%b avail %b/%b (actual/expected)",
                             e.tag, rr2_vec, e.vec, rr3_pend, e.pend,
                             irq, e.irq, rx_avail, e.av);
                end
            end
        end
    end

    // driver: one strobe cycle, then one quiet cycle
    task automatic op(input logic [1:0] rx, input logic [1:0] tx,
                      input logic [1:0] rd, input logic cw, input logic cc,
                      input logic [2:0] code, input logic [7:0] ev,
                      input logic [7:0] ep, input logic ei,
                      input logic [1:0] ea, input string tag);
        exp_t e;
        @(negedge clk);
        rx_evt = rx; tx_evt = tx; data_rd = rd;
        cmd_we = cw; cmd_chan = cc; cmd_code = code;
        e.vec = ev; e.pend = ep; e.irq = ei; e.av = ea; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        rx_evt = 2'b00; tx_evt = 2'b00; data_rd = 2'b00;
        cmd_we = 1'b0; cmd_chan = 1'b0; cmd_code = 3'd0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        op(0,0,0,0,0,0, 8'h00,8'h00,0,2'b00, "R1 reset state");

        // low encoding, channel A lockout and re-raise
        op(2'b01,0,0,0,0,0, 8'h0C,8'h20,1,2'b01, "R2 R4 rx A");
        op(0,2'b01,0,0,0,0, 8'h0C,8'h30,1,2'b01, "R5 R3 tx A locked out");
        op(0,0,0,1,0,3'd7, 8'h08,8'h10,1,2'b01, "R6 R8 reset IUS rx -> tx");
        op(0,0,2'b01,0,0,0, 8'h08,8'h10,1,2'b00, "R9 R8 data read A keeps tx");
        op(0,0,0,1,0,3'd5, 8'h06,8'h00,0,2'b00, "R7 clear tx A");
        op(0,0,0,0,0,0, 8'h06,8'h00,0,2'b00, "R13 idle hold");

        // high encoding, channel B
        status_hi = 1'b1;
        op(2'b10,0,0,0,0,0, 8'h20,8'h04,1,2'b10, "R4 rx B hi");
        op(0,2'b10,0,0,0,0, 8'h20,8'h06,1,2'b10, "R5 tx B locked out");
        op(0,0,2'b10,0,0,0, 8'h00,8'h02,1,2'b00, "R8 R9 read B raises tx B");
        op(0,0,0,1,1,3'd7, 8'h60,8'h00,0,2'b00, "R6 reset IUS tx B");
        op(0,2'b01,0,0,0,0, 8'h10,8'h10,1,2'b00, "R4 tx A hi");
        op(0,0,0,1,0,3'd5, 8'h60,8'h00,0,2'b00, "R7 clear tx A hi");
        op(2'b01,0,0,0,0,0, 8'h30,8'h20,1,2'b01, "R4 rx A hi");
        op(0,0,2'b01,0,0,0, 8'h60,8'h00,0,2'b00, "R9 read A hi");

        // enable gating
        rx_mode = 4'b0100;
        op(2'b01,0,0,0,0,0, 8'h30,8'h20,0,2'b01, "R10 rx mode 00 gated");
        rx_mode = 4'b0111;
        op(0,0,0,0,0,0, 8'h30,8'h20,0,2'b01, "R10 rx mode 11 gated");
        rx_mode = 4'b0110;
        op(0,0,0,0,0,0, 8'h30,8'h20,1,2'b01, "R10 rx mode 10 enabled");
        op(0,0,2'b01,0,0,0, 8'h60,8'h00,0,2'b00, "R9 read clears");
        rx_mode = 4'b0101;
        tx_ie = 2'b10;
        op(0,2'b01,0,0,0,0, 8'h10,8'h10,0,2'b00, "R10 tx enable gated");
        tx_ie = 2'b11;
        op(0,0,0,0,0,0, 8'h10,8'h10,1,2'b00, "R10 tx enable on");
        op(0,0,0,1,0,3'd5, 8'h60,8'h00,0,2'b00, "R7 clear tx A");
        brk_ie = 2'b10; brk_stat = 2'b10;
        op(0,0,0,0,0,0, 8'h60,8'h00,1,2'b00, "R10 break B");
        brk_ie = 2'b00;
        op(0,0,0,0,0,0, 8'h60,8'h00,0,2'b00, "R10 break disabled");
        brk_stat = 2'b00;
        op(0,0,0,1,0,3'd7, 8'h60,8'h00,0,2'b00, "R6 reset IUS idle no effect");

        // both channels, set wins
        status_hi = 1'b0;
        op(2'b11,0,0,0,0,0, 8'h0C,8'h24,1,2'b11, "R12 both rx A wins");
        op(0,0,2'b11,0,0,0, 8'h06,8'h00,0,2'b00, "R9 read both");
        op(0,2'b01,0,0,0,0, 8'h08,8'h10,1,2'b00, "R3 tx A lo");
        op(0,2'b01,0,1,0,3'd5, 8'h08,8'h10,1,2'b00, "R11 tx set beats clear");
        op(0,0,0,1,0,3'd5, 8'h06,8'h00,0,2'b00, "R7 clear tx A");
        op(2'b01,0,2'b01,0,0,0, 8'h0C,8'h20,1,2'b01, "R11 rx set beats read");
        op(0,0,2'b01,0,0,0, 8'h06,8'h00,0,2'b00, "R9 read A");
        op(0,2'b10,0,0,0,0, 8'h00,8'h02,1,2'b00, "R4 tx B lo");
        op(0,0,0,1,1,3'd7, 8'h06,8'h00,0,2'b00, "R6 reset IUS tx B lo");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule